// File: doc/BRIEF.md
# E1 CRC-4 Check Field Inserter

This block sits in the serial path of an E1 stream of 256-bit frames and rewrites the four CRC-4 check bits of every sub-multiframe on their way out. It keeps its own bit counter and frame counter. It aligns them to a frame-start marker that arrives with the first bit of a frame, and it then counts eight-frame sub-multiframes from that point. All other bits go through unchanged with one clock of latency.

A two-bit policy input selects how the check positions are filled, and it can be changed while traffic runs. In regenerate mode the block computes CRC-4 over each sub-multiframe it forwards and writes the remainder into the next sub-multiframe. In host mode a 4-bit value that software holds in a register is written into every sub-multiframe until it is changed. In pass mode the check positions keep the values they arrived with. A new policy or host value is taken only at a sub-multiframe boundary, so a check field is never a mix of two sources.

Top module: `e1_crc_insert`

## Requirements
- R1: `out_vld` equals `bit_vld` delayed by one clock; after reset `out_vld` and `out_bit` are 0.
- R2: Every bit that is not a check position appears on `out_bit` unchanged, one clock after it is accepted.
- R3: A bit accepted with `frm_start` high is bit 0 of a frame. The first such bit starts frame 0. Frames then count 0 to 7 and wrap, each 256 accepted bits long. The check positions are bit 0 of frames 0, 2, 4 and 6, which carry C1, C2, C3 and C4 in that order. Bits accepted before the first `frm_start` pass unchanged.
- R4: With mode 2'b01 (regenerate), C1..C4 carry the remainder of the previous sub-multiframe's 2048 bits times x^4, divided by x^4 + x + 1. The previous sub-multiframe's check positions count as zero, the first bit of a sub-multiframe is the highest-order coefficient, and C1 is the x^3 coefficient of the remainder.
- R5: With mode 2'b10 (host), C1..C4 carry `host_crc[3]`..`host_crc[0]` in every sub-multiframe.
- R6: With mode 2'b00 or 2'b11 (pass), the check positions leave unchanged.
- R7: `mode` and `host_crc` are sampled only with the bit at a sub-multiframe boundary (bit 0 of frame 0). That same bit already follows the newly sampled values, and changes made at other times have no effect until the next boundary.
- R8: In regenerate mode, a sub-multiframe carries zeros in C1..C4 when the sub-multiframe before it did not run in regenerate mode. This includes the first sub-multiframe after reset.
- R9: While `bit_vld` is low the counters, the held policy and `out_bit` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Strobe: `bit_in` carries a line bit this cycle |
| bit_in | input | 1 | Incoming serial E1 bit |
| frm_start | input | 1 | High with the first bit of a frame |
| mode | input | 2 | Check-field policy: 00/11 pass, 01 regenerate, 10 host value |
| host_crc | input | 4 | Host-held check value, bit 3 goes to C1 |
| out_bit | output | 1 | Outgoing serial bit |
| out_vld | output | 1 | Strobe for `out_bit` |

## Verification
The policy and the host value are sampled at the boundary, and C1 is inserted in that same cycle. Both therefore fall on the same bit. The bench provokes this by changing `mode` exactly with the boundary bit, and it expects C1 to follow the new policy at once. It also changes `host_crc` and `mode` in the middle of a sub-multiframe, and there it expects every check bit to keep the old source until the next boundary. The scoreboard computes each expected check bit by polynomial long division over a stored copy of the sub-multiframe. Random gaps in `bit_vld` test that the counters and the output hold still while no bit is accepted.

// File: rtl/e1_crc_pkg.sv
package e1_crc_pkg;
  typedef enum logic [1:0] {
    CM_PASS  = 2'b00,
    CM_REGEN = 2'b01,
    CM_HOST  = 2'b10,
    CM_KEEP  = 2'b11
  } crc_mode_e;

  localparam int unsigned CRC_W = 4;
endpackage

// File: rtl/e1_frame_track.sv
module e1_frame_track #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned SMF_FRAMES = 8,
  localparam int unsigned PW = $clog2(FRAME_BITS),
  localparam int unsigned FW = $clog2(SMF_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_vld,
  input  logic          frm_start,
  output logic          crc_slot,
  output logic          smf_edge,
  output logic [FW-2:0] crc_idx
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

  logic          started_q, started_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [FW-1:0] frame_q, frame_d;
  logic          new_frame, live, upd;

  always_comb begin
    if (frm_start)          pos_d = '0;
    else if (pos_q == LAST) pos_d = '0;
    else                    pos_d = pos_q + 1'b1;

    new_frame = started_q ? (pos_d == '0) : frm_start;

    if (!started_q)     frame_d = '0;
    else if (new_frame) frame_d = frame_q + 1'b1;
    else                frame_d = frame_q;

    live      = started_q | frm_start;
    upd       = bit_vld & live;
    started_d = started_q | frm_start;
    crc_slot  = upd & (pos_d == '0) & ~frame_d[0];
    smf_edge  = upd & new_frame & (frame_d == '0);
    crc_idx   = frame_d[FW-1:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      pos_q     <= '0;
      frame_q   <= '0;
    end else if (upd) begin
      started_q <= started_d;
      pos_q     <= pos_d;
      frame_q   <= frame_d;
    end
  end
endmodule

// File: rtl/e1_crc4_acc.sv
module e1_crc4_acc #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         din,
  output logic [W-1:0] rem
);
  logic [W-1:0] rem_q, rem_d, base;
  logic         fb;

  always_comb begin
    base  = clr ? '0 : rem_q;
    fb    = din ^ base[W-1];
    rem_d = {base[W-2:0], 1'b0} ^ ({W{fb}} & W'(4'b0011));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rem_q <= '0;
    else if (en) rem_q <= rem_d;
  end

  assign rem = rem_q;
endmodule

// File: rtl/e1_crc_insert.sv
module e1_crc_insert
  import e1_crc_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned SMF_FRAMES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             frm_start,
  input  logic [1:0]       mode,
  input  logic [CRC_W-1:0] host_crc,
  output logic             out_bit,
  output logic             out_vld
);
  localparam int unsigned FW = $clog2(SMF_FRAMES);
  localparam logic [FW-2:0] TOPI = (FW-1)'(CRC_W - 1);

  logic [1:0]       rsync_q;
  logic             rst_i_n;
  logic             crc_slot, smf_edge;
  logic [FW-2:0]    crc_idx;
  logic [CRC_W-1:0] rem;
  crc_mode_e        mode_in, mode_q, mode_d;
  logic [CRC_W-1:0] vec_q, vec_d, vec_use;
  logic             ins_on, out_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  e1_frame_track #(.FRAME_BITS(FRAME_BITS), .SMF_FRAMES(SMF_FRAMES)) u_trk (
    .clk(clk), .rst_n(rst_i_n), .bit_vld(bit_vld), .frm_start(frm_start),
    .crc_slot(crc_slot), .smf_edge(smf_edge), .crc_idx(crc_idx)
  );

  e1_crc4_acc #(.W(CRC_W)) u_acc (
    .clk(clk), .rst_n(rst_i_n), .en(bit_vld), .clr(smf_edge),
    .din(bit_in & ~crc_slot), .rem(rem)
  );

  always_comb begin
    mode_in = crc_mode_e'(mode);
    mode_d  = mode_q;
    vec_d   = vec_q;
    if (smf_edge) begin
      mode_d = mode_in;
      case (mode_in)
        CM_REGEN: vec_d = (mode_q == CM_REGEN) ? rem : '0;
        CM_HOST:  vec_d = host_crc;
        default:  vec_d = '0;
      endcase
    end
    vec_use = vec_d;
    ins_on  = (mode_d == CM_REGEN) || (mode_d == CM_HOST);
    out_d   = (crc_slot && ins_on) ? vec_use[TOPI - crc_idx] : bit_in;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mode_q  <= CM_PASS;
      vec_q   <= '0;
      out_bit <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= bit_vld;
      if (bit_vld) begin
        out_bit <= out_d;
        mode_q  <= mode_d;
        vec_q   <= vec_d;
      end
    end
  end
endmodule

// File: rtl/e1_crc_insert_chk.sv
module e1_crc_insert_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_vld,
  input logic       bit_in,
  input logic       out_bit,
  input logic       out_vld,
  input logic       crc_slot,
  input logic       smf_edge,
  input logic [1:0] mode_q,
  input logic [3:0] vec_q
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> out_vld);

  a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> !out_vld);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(out_bit));

  a_r2_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !crc_slot) |=> (out_bit == $past(bit_in)));

  a_r6_pass_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && crc_slot && !smf_edge && (mode_q == 2'b00 || mode_q == 2'b11))
    |=> (out_bit == $past(bit_in)));

  a_r7_policy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smf_edge |=> ($stable(vec_q) && $stable(mode_q)));

  a_r3_edge_is_slot: assert property (@(posedge clk) disable iff (!rst_n)
    smf_edge |-> crc_slot);
endmodule

bind e1_crc_insert e1_crc_insert_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
  .out_bit(out_bit), .out_vld(out_vld), .crc_slot(crc_slot),
  .smf_edge(smf_edge), .mode_q(mode_q), .vec_q(vec_q)
);

// File: tb/tb_e1_crc_insert.sv
module tb_e1_crc_insert;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_vld = 1'b0, bit_in = 1'b0, frm_start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [3:0] host_crc = 4'h0;
  logic       out_bit, out_vld;

  always #4 clk = ~clk;

  e1_crc_insert dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .frm_start(frm_start), .mode(mode), .host_crc(host_crc),
    .out_bit(out_bit), .out_vld(out_vld)
  );

  int n_chk = 0, n_err = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit    last_out = 1'b0;
  bit    mon_on = 1'b0;

  bit         smf_bits[2048];
  bit         started = 1'b0;
  int         frame = 0;
  logic [1:0] eff_mode = 2'b00;
  logic [3:0] eff_vec = 4'h0;
  bit         zero_fill = 1'b0;
  bit         pend_chg = 1'b0, smf_chg = 1'b0;

  task automatic chk(input bit got, input bit exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [3:0] crc_div();
    logic [4:0] w = 5'b0;
    for (int i = 0; i < 2052; i++) begin
      w = {w[3:0], (i < 2048) ? smf_bits[i] : 1'b0};
      if (w[4]) w = w ^ 5'b10011;
    end
    return w[3:0];
  endfunction

  always @(negedge clk) begin
    if (mon_on && out_vld) begin
      if (exp_q.size() == 0) chk(1'b1, 1'b0, "R1 unexpected output");
      else begin
        chk(out_bit, exp_q.pop_front(), tag_q.pop_front());
        last_out = out_bit;
      end
    end
  end

  task automatic send_bit(input bit d, input bit fs, input int pos);
    bit is_crc, e;
    string t;
    if ($urandom % 9 == 0) begin
      bit_vld = 1'b0; bit_in = ~d; frm_start = 1'b0;
      @(negedge clk);
      chk(out_vld, 1'b0, "R9 valid during gap");
      chk(out_bit, last_out, "R9 output held during gap");
    end
    bit_vld = 1'b1; bit_in = d; frm_start = fs;
    if (fs) begin
      frame = started ? (frame + 1) % 8 : 0;
      started = 1'b1;
    end
    is_crc = started && pos == 0 && frame % 2 == 0;
    if (started && pos == 0 && frame == 0) begin
      zero_fill = 1'b0;
      if (mode == 2'b01) begin
        if (eff_mode == 2'b01) eff_vec = crc_div();
        else begin eff_vec = 4'h0; zero_fill = 1'b1; end
      end else if (mode == 2'b10) eff_vec = host_crc;
      eff_mode = mode;
      smf_chg = pend_chg; pend_chg = 1'b0;
    end
    if (started) smf_bits[frame*256 + pos] = is_crc ? 1'b0 : d;
    if (!started) begin e = d; t = "R3 bit before alignment"; end
    else if (!is_crc) begin e = d; t = "R2 data bit"; end
    else if (eff_mode == 2'b00 || eff_mode == 2'b11) begin e = d; t = "R6 pass slot"; end
    else begin
      e = eff_vec[3 - frame/2];
      if (smf_chg) t = "R7 boundary-sampled slot";
      else if (zero_fill) t = "R8 zero-filled slot";
      else if (eff_mode == 2'b01) t = "R4 regenerated slot";
      else t = "R5 host slot";
    end
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic send_frames(input int n);
    for (int f = 0; f < n; f++)
      for (int p = 0; p < 256; p++) send_bit(1'($urandom), p == 0, p);
  endtask

  task automatic request(input logic [1:0] m, input logic [3:0] h);
    mode = m; host_crc = h; pend_chg = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_vld, 1'b0, "R1 reset valid");
    chk(out_bit, 1'b0, "R1 reset data");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0, 0);
    mode = 2'b01;
    send_frames(24);
    send_frames(3); request(2'b10, 4'b1010);
    send_frames(5); send_frames(8);
    send_frames(4); request(2'b10, 4'b0101);
    send_frames(4); send_frames(8);
    request(2'b00, 4'b1111);
    send_frames(8);
    request(2'b11, 4'b0000);
    send_frames(8);
    request(2'b01, 4'b0000);
    send_frames(16);
    bit_vld = 1'b0; frm_start = 1'b0;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, 1'b1, "R1 all outputs delivered");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule